// File: doc/BRIEF.md
# Masked Chained Vector Averaging Unit

This block is a pipelined vector functional unit that forms the element-wise rounded-down mean of two signed operand streams, result[i] = floor((A[i] + B[i]) / 2). A caller starts a pass by giving it a requested element count and a per-element enable mask. The unit then takes operand pairs directly from two independent load streams, with no register-file write-back in between. An element enters the pipeline in the cycle that both of its operands are available. When a steady supply arrives from both sides, one element retires per clock.

Each stream can park one operand that arrives ahead of its partner, so the two loads may run with different timing. Every element travels down the three-stage datapath with its valid bit, its index and its mask bit. Elements whose mask bit is clear still leave the pipe in their slot, but with the write strobe low, so the destination element keeps its old value. A pass never covers more elements than the register capacity. The unit reports how many elements it took, and the caller covers a longer vector by starting further passes on the remainder.

Top module: `vavg_chain_unit`

## Requirements
- R1: After reset, out_valid, out_we, done, busy, a_ready and b_ready are all low.
- R2: out_data is floor((A+B)/2) of the two ELEM_W-bit two's-complement operands. The sum is formed one bit wider, so extreme operands never wrap. Examples: 32767+32767 gives 32767, -32768+-32768 gives -32768, -3+0 gives -2, 32767+-32768 gives -1.
- R3: Element i pairs the i-th operand accepted on stream A with the i-th operand accepted on stream B, whatever the relative timing of the two streams. A stream holding an unpartnered operand drives its ready low.
- R4: Bit i of cfg_mask (bit 0 belongs to element 0) is latched at start. When the bit is 1, the element leaves with out_valid and out_we high. When it is 0, out_valid is high and out_we is low.
- R5: A pass takes exactly min(cfg_len, MAX_LEN) elements, and taken_len shows that count from the cycle after start. Both ready outputs stay low while the unit is idle and once the count has been reached.
- R6: A result appears on the outputs after the third rising edge, counting the edge that accepted its operand pair. With both streams valid every cycle, results leave on consecutive cycles.
- R7: done pulses for exactly one cycle, together with the output of the last element (index taken_len-1). For a zero-length pass it pulses in the cycle after start. busy falls one cycle after done.
- R8: A start while busy is ignored: the running pass keeps its length and mask.
- R9: out_idx carries each element's position within the pass, in ascending order.
- R10: A total of 527 elements with MAX_LEN 64 is covered by 9 passes. The last pass takes 15 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a pass, accepted when not busy |
| cfg_len | input | REQ_W | Requested element count |
| cfg_mask | input | MAX_LEN | Per-element enable, bit i for element i |
| a_valid | input | 1 | Stream A operand valid |
| a_data | input | ELEM_W | Stream A operand |
| a_ready | output | 1 | Stream A operand accepted at this edge if valid |
| b_valid | input | 1 | Stream B operand valid |
| b_data | input | ELEM_W | Stream B operand |
| b_ready | output | 1 | Stream B operand accepted at this edge if valid |
| busy | output | 1 | Pass in progress |
| taken_len | output | clog2(MAX_LEN+1) | Elements covered by the current pass |
| out_valid | output | 1 | An element leaves the pipeline |
| out_we | output | 1 | Write strobe for that element (mask bit) |
| out_idx | output | clog2(MAX_LEN) | Element index |
| out_data | output | ELEM_W | Averaged result |
| done | output | 1 | Last element of the pass is leaving |

## Verification
The operand streams are driven in lockstep, with stream B lagging, and with stream A lagging. Lockstep exposes throughput and latency faults. The skewed cases show whether the park registers pair the right operands. Masks with mixed, sparse and all-ones patterns separate dropped elements from elements that keep their slot with the strobe low. Operand pairs at the signed extremes and odd negative sums catch a narrow adder or a logical shift. A 527-element run checks the clamp and the split into passes, including the short final pass.

// File: rtl/vavg_pkg.sv
package vavg_pkg;
  // per-element sideband carried alongside the data through every stage
  typedef struct packed {
    logic we;    // mask bit of this element
    logic last;  // final element of the pass
  } vavg_tag_t;
endpackage

// File: rtl/vavg_pair_join.sv
module vavg_pair_join #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         in_valid [2],
  input  logic [W-1:0] in_data  [2],
  output logic         in_ready [2],
  output logic         fire,
  output logic [W-1:0] op_a,
  output logic [W-1:0] op_b
);
  logic         park_v [2];
  logic [W-1:0] park_d [2];
  logic         have   [2];
  logic [W-1:0] cur    [2];

  for (genvar s = 0; s < 2; s++) begin : g_lane
    assign in_ready[s] = accept && !park_v[s];
    assign have[s]     = park_v[s] || (in_valid[s] && in_ready[s]);
    assign cur[s]      = park_v[s] ? park_d[s] : in_data[s];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        park_v[s] <= 1'b0;
      end else if (fire) begin
        park_v[s] <= 1'b0;
      end else if (in_valid[s] && in_ready[s]) begin
        park_v[s] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!fire && in_valid[s] && in_ready[s]) park_d[s] <= in_data[s];
    end
  end

  assign fire = accept && have[0] && have[1];
  assign op_a = cur[0];
  assign op_b = cur[1];

  // two parked operands would have formed a pair already
  assert_single_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(park_v[0] && park_v[1]));
endmodule

// File: rtl/vavg_seq_ctrl.sv
module vavg_seq_ctrl
  import vavg_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int REQ_W   = 16,
  parameter int LEN_W   = 7,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [REQ_W-1:0]   cfg_len,
  input  logic [MAX_LEN-1:0] cfg_mask,
  input  logic               fire,
  input  logic               done_in,
  output logic               accept,
  output logic               busy,
  output logic [LEN_W-1:0]   len_q,
  output logic [IDX_W-1:0]   el_idx,
  output vavg_tag_t          el_tag,
  output logic               zero_done
);
  logic               active;
  logic [LEN_W-1:0]   cnt;
  logic [MAX_LEN-1:0] mask_q;
  logic               launch;
  logic [LEN_W-1:0]   len_eff;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [REQ_W-1:0] req);
    if (req > REQ_W'(MAX_LEN)) return LEN_W'(MAX_LEN);
    return req[LEN_W-1:0];
  endfunction

  assign launch  = start && !active;
  assign len_eff = clamp_len(cfg_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      len_q     <= '0;
      mask_q    <= '0;
      zero_done <= 1'b0;
    end else begin
      zero_done <= launch && (len_eff == '0);
      if (launch) begin
        active <= 1'b1;
        cnt    <= '0;
        len_q  <= len_eff;
        mask_q <= cfg_mask;
      end else begin
        if (fire) cnt <= cnt + LEN_W'(1);
        if (active && done_in) active <= 1'b0;
      end
    end
  end

  assign busy        = active;
  assign accept      = active && (cnt < len_q);
  assign el_idx      = cnt[IDX_W-1:0];
  assign el_tag.we   = mask_q[el_idx];
  assign el_tag.last = (cnt + LEN_W'(1)) == len_q;

  assert_issue_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= len_q);
  assert_len_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_W'(MAX_LEN));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start) |=> (len_q == $past(len_q)) && (mask_q == $past(mask_q)));
endmodule

// File: rtl/vavg_pipe.sv
module vavg_pipe
  import vavg_pkg::*;
#(
  parameter int W     = 16,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_fire,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [IDX_W-1:0] in_idx,
  input  vavg_tag_t        in_tag,
  output logic             out_valid,
  output logic             out_we,
  output logic             out_last,
  output logic [IDX_W-1:0] out_idx,
  output logic [W-1:0]     out_data
);
  // sign-extended sum, one bit wider than the operands
  function automatic logic [W:0] wide_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    return {a[W-1], a} + {b[W-1], b};
  endfunction

  // arithmetic shift right by one, truncated back to W bits
  function automatic logic [W-1:0] halve(input logic [W:0] s);
    return s[W:1];
  endfunction

  logic             s0_v, s1_v, s2_v;
  logic [W-1:0]     s0_a, s0_b, s2_d;
  logic [W:0]       s1_sum;
  logic [IDX_W-1:0] s0_idx, s1_idx, s2_idx;
  vavg_tag_t        s0_tag, s1_tag, s2_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_v <= 1'b0;
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s0_v <= in_fire;
      s1_v <= s0_v;
      s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    s0_a   <= in_a;
    s0_b   <= in_b;
    s0_idx <= in_idx;
    s0_tag <= in_tag;
    s1_sum <= wide_sum(s0_a, s0_b);
    s1_idx <= s0_idx;
    s1_tag <= s0_tag;
    s2_d   <= halve(s1_sum);
    s2_idx <= s1_idx;
    s2_tag <= s1_tag;
  end

  assign out_valid = s2_v;
  assign out_we    = s2_v && s2_tag.we;
  assign out_last  = s2_v && s2_tag.last;
  assign out_idx   = s2_idx;
  assign out_data  = s2_d;

  assert_valid_travels_s1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s0_v |=> s1_v);
  assert_valid_travels_s2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> s2_v);
endmodule

// File: rtl/vavg_chain_unit.sv
module vavg_chain_unit
  import vavg_pkg::*;
#(
  parameter int ELEM_W  = 16,
  parameter int MAX_LEN = 64,
  parameter int REQ_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [REQ_W-1:0]             cfg_len,
  input  logic [MAX_LEN-1:0]           cfg_mask,
  input  logic                         a_valid,
  input  logic [ELEM_W-1:0]            a_data,
  output logic                         a_ready,
  input  logic                         b_valid,
  input  logic [ELEM_W-1:0]            b_data,
  output logic                         b_ready,
  output logic                         busy,
  output logic [$clog2(MAX_LEN+1)-1:0] taken_len,
  output logic                         out_valid,
  output logic                         out_we,
  output logic [$clog2(MAX_LEN)-1:0]   out_idx,
  output logic [ELEM_W-1:0]            out_data,
  output logic                         done
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int IDX_W = $clog2(MAX_LEN);

  logic              accept, fire, zero_done, pipe_last;
  logic [ELEM_W-1:0] op_a, op_b;
  logic [IDX_W-1:0]  el_idx;
  vavg_tag_t         el_tag;
  logic              lane_valid [2];
  logic [ELEM_W-1:0] lane_data  [2];
  logic              lane_ready [2];

  assign lane_valid[0] = a_valid;
  assign lane_valid[1] = b_valid;
  assign lane_data[0]  = a_data;
  assign lane_data[1]  = b_data;
  assign a_ready       = lane_ready[0];
  assign b_ready       = lane_ready[1];
  assign done          = pipe_last || zero_done;

  vavg_seq_ctrl #(
    .MAX_LEN(MAX_LEN), .REQ_W(REQ_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
    .cfg_mask(cfg_mask), .fire(fire), .done_in(done), .accept(accept),
    .busy(busy), .len_q(taken_len), .el_idx(el_idx), .el_tag(el_tag),
    .zero_done(zero_done)
  );

  vavg_pair_join #(.W(ELEM_W)) u_join (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_valid(lane_valid),
    .in_data(lane_data), .in_ready(lane_ready), .fire(fire),
    .op_a(op_a), .op_b(op_b)
  );

  vavg_pipe #(.W(ELEM_W), .IDX_W(IDX_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_fire(fire), .in_a(op_a), .in_b(op_b),
    .in_idx(el_idx), .in_tag(el_tag), .out_valid(out_valid),
    .out_we(out_we), .out_last(pipe_last), .out_idx(out_idx),
    .out_data(out_data)
  );

  assert_we_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_valid);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!a_ready && !b_ready));
endmodule

// File: tb/test_vavg_chain_unit.sv
`timescale 1ns/1ps
module test_vavg_chain_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cfg_len = '0;
  logic [63:0] cfg_mask = '0;
  logic        a_valid = 1'b0, b_valid = 1'b0;
  logic [15:0] a_data = '0, b_data = '0;
  logic        a_ready, b_ready, busy, out_valid, out_we, done;
  logic [6:0]  taken_len;
  logic [5:0]  out_idx;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [15:0] va [64];
  logic [15:0] vb [64];
  logic [15:0] got_d [64];
  logic        got_we [64];
  int          got_idx [64];
  int          got_cyc [64];
  int          got_n = 0;
  int          done_n = 0;
  int          done_idx = -1;

  always #2.5 clk = ~clk;

  vavg_chain_unit i_vavg_chain_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
    .cfg_mask(cfg_mask), .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
    .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready), .busy(busy),
    .taken_len(taken_len), .out_valid(out_valid), .out_we(out_we),
    .out_idx(out_idx), .out_data(out_data), .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && got_n < 64) begin
      got_d[got_n]   = out_data;
      got_we[got_n]  = out_we;
      got_idx[got_n] = int'(out_idx);
      got_cyc[got_n] = cyc;
      got_n++;
    end
    if (done) begin
      done_n++;
      done_idx = out_valid ? int'(out_idx) : -1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int exp_avg(input logic [15:0] a, input logic [15:0] b);
    int s;
    s = int'($signed(a)) + int'($signed(b));
    if (s >= 0) return s / 2;
    return -((1 - s) / 2);
  endfunction

  task automatic drive_a(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      if (gap > 0) begin
        @(negedge clk) a_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
      @(negedge clk);
      a_valid = 1'b1;
      a_data  = va[i];
      while (!a_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk) a_valid = 1'b0;
  endtask

  task automatic drive_b(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      if (gap > 0) begin
        @(negedge clk) b_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
      @(negedge clk);
      b_valid = 1'b1;
      b_data  = vb[i];
      while (!b_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk) b_valid = 1'b0;
  endtask

  // one pass; seed < 0 keeps the preloaded operands
  task automatic run_pass(input int len, input logic [63:0] m, input int ga,
                          input int gb, input int seed, input bit poke);
    int n;
    int k;
    n = (len > 64) ? 64 : len;
    if (seed >= 0) begin
      for (int i = 0; i < n; i++) begin
        va[i] = 16'(i * 1031 + seed * 977 - 9000);
        vb[i] = 16'(seed * 311 - i * 733 + 4000);
      end
    end
    @(negedge clk);
    start = 1'b1; cfg_len = 16'(len); cfg_mask = m;
    @(posedge clk);
    got_n = 0; done_n = 0; done_idx = -1;
    @(negedge clk) start = 1'b0;
    chk(int'(taken_len) == n, "R5", "taken_len", int'(taken_len), n);
    fork
      drive_a(n, ga);
      drive_b(n, gb);
      begin
        if (poke) begin
          repeat (3) @(negedge clk);
          start = 1'b1; cfg_len = 16'd2; cfg_mask = '0;
          @(negedge clk) start = 1'b0;
        end
      end
    join
    k = 0;
    while (done_n == 0 && k < 200) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk);
    chk(got_n == n, poke ? "R8" : "R5", "element count", got_n, n);
    for (int i = 0; i < got_n; i++) begin
      chk(got_idx[i] == i, "R9", "out_idx", got_idx[i], i);
      chk(int'($signed(got_d[i])) == exp_avg(va[i], vb[i]), "R2/R3", "out_data",
          int'($signed(got_d[i])), exp_avg(va[i], vb[i]));
      chk(got_we[i] == m[i], poke ? "R8" : "R4", "out_we", int'(got_we[i]), int'(m[i]));
    end
    chk(done_n == 1, "R7", "done pulses", done_n, 1);
    chk(done_idx == n - 1, "R7", "done index", done_idx, n - 1);
    chk(busy == 1'b0, "R7", "busy after done", int'(busy), 0);
    if (ga == 0 && gb == 0) begin
      for (int i = 1; i < got_n; i++)
        chk(got_cyc[i] - got_cyc[0] == i, "R6", "back-to-back spacing",
            got_cyc[i] - got_cyc[0], i);
    end
  endtask

  task automatic t_reset();
    chk(!out_valid && !out_we && !done, "R1", "outputs idle",
        int'({out_valid, out_we, done}), 0);
    chk(!busy && !a_ready && !b_ready, "R1", "control idle",
        int'({busy, a_ready, b_ready}), 0);
  endtask

  task automatic t_latency();
    va[0] = 16'd100; vb[0] = 16'd51;
    @(negedge clk);
    start = 1'b1; cfg_len = 16'd1; cfg_mask = 64'h1;
    @(negedge clk);
    start = 1'b0;
    chk(a_ready && b_ready, "R5", "ready after start", int'({a_ready, b_ready}), 3);
    a_valid = 1'b1; a_data = va[0]; b_valid = 1'b1; b_data = vb[0];
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b0;
    chk(!out_valid, "R6", "no result after 1 edge", int'(out_valid), 0);
    @(negedge clk);
    chk(!out_valid, "R6", "no result after 2 edges", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid && done, "R6", "result after 3 edges", int'({out_valid, done}), 3);
    chk(int'($signed(out_data)) == 75, "R2", "latency data", int'($signed(out_data)), 75);
    @(negedge clk);
    chk(!busy, "R7", "busy low after done", int'(busy), 0);
  endtask

  task automatic t_zero_len();
    @(negedge clk);
    start = 1'b1; cfg_len = 16'd0; cfg_mask = '1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !out_valid, "R7", "zero-length done", int'({done, out_valid}), 2);
    chk(!a_ready && !b_ready, "R5", "zero-length no ready", int'({a_ready, b_ready}), 0);
    @(negedge clk);
    chk(!done && !busy, "R7", "zero-length ends", int'({done, busy}), 0);
  endtask

  task automatic t_extremes();
    va[0] = 16'h7fff; vb[0] = 16'h7fff;
    va[1] = 16'h8000; vb[1] = 16'h8000;
    va[2] = 16'hfffd; vb[2] = 16'h0000;
    va[3] = 16'h7fff; vb[3] = 16'h8000;
    va[4] = 16'h0003; vb[4] = 16'h0000;
    va[5] = 16'hffff; vb[5] = 16'hfffe;
    run_pass(6, 64'h3f, 0, 0, -1, 1'b0);
    chk(int'($signed(got_d[2])) == -2, "R2", "odd negative rounds down",
        int'($signed(got_d[2])), -2);
  endtask

  task automatic t_stripmine();
    int rem;
    int passes;
    int last;
    rem = 527; passes = 0; last = 0;
    while (rem > 0 && passes < 12) begin
      run_pass(rem, '1, 0, 0, passes + 20, 1'b0);
      last = int'(taken_len);
      rem -= last;
      passes++;
    end
    chk(passes == 9, "R10", "pass count", passes, 9);
    chk(last == 15, "R10", "final chunk", last, 15);
  endtask

  initial begin
    #900_000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();                                        // R1
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();                                        // R1
    t_latency();                                      // R6
    run_pass(8, 64'hff, 0, 0, 1, 1'b0);               // R2 R6 lockstep
    run_pass(10, 64'h2b5, 0, 2, 2, 1'b0);             // R3 B lags, R4 mask
    run_pass(9, 64'h101, 3, 0, 3, 1'b0);              // R3 A lags, sparse mask
    run_pass(5, 64'h0, 1, 1, 4, 1'b0);                // R4 all masked
    t_extremes();                                     // R2
    run_pass(100, '1, 0, 1, 5, 1'b0);                 // R5 clamp to 64
    run_pass(6, 64'h2d, 0, 0, 6, 1'b1);               // R8 start ignored
    t_zero_len();                                     // R7
    t_stripmine();                                    // R10
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule